// File: doc/BRIEF.md
# Serial Byte Transmitter with 16-Entry Queue

This block turns bytes written by a host into asynchronous serial frames on a single output line. A host writes a byte by holding `wr_en` high for one clock with the byte on `wr_data`. The byte goes into a 16-entry first-in first-out queue. A serializer takes bytes from the head of the queue and sends each one as a frame with one start bit, eight data bits and one stop bit, with no parity bit.

The block has no baud divider. All bit timing follows `baud16_en`, a one-cycle enable pulse that a shared divider elsewhere produces at sixteen times the bit rate. While the queue holds data the frames follow one another with no idle gap. Two level flags tell the host how much room is left. A synchronous clear input empties the queue without cutting short the frame already on the line.

Top module: `serial_tx_queue`

## Requirements
- R1: After `rst`, `txd` is high (idle) and `full` and `half_full` are both low.
- R2: A frame is a low start bit, then the eight data bits with bit 0 first, then a high stop bit.
- R3: Every serial bit lasts exactly 16 cycles on which `baud16_en` is high. On cycles where `baud16_en` is low, `txd` does not change.
- R4: A one-cycle `wr_en` pulse appends `wr_data` to the tail of the queue when the queue is not full. Bytes are sent in the order they were written.
- R5: When the queue holds data and the serializer is idle, a start bit begins on the next clock edge that has `baud16_en` high. When a stop bit ends and the queue is not empty, the next start bit begins on that same edge. When the queue is empty, `txd` goes back to idle high.
- R6: `full` is high exactly when the queue holds 16 bytes.
- R7: `half_full` is high exactly when the queue holds 8 or more bytes.
- R8: A write while `full` is high is dropped. It does not change the stored bytes or their order, which the later serial output shows.
- R9: `buf_clr` empties the queue on the next edge, and this takes priority over a write in the same cycle. A frame already being shifted out still finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_clr | input | 1 | Synchronous queue clear |
| baud16_en | input | 1 | One-cycle enable at 16x the bit rate |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| txd | output | 1 | Serial output, idle high |
| full | output | 1 | Queue holds 16 bytes |
| half_full | output | 1 | Queue holds 8 or more bytes |

## Verification
The outputs are registered. `full` and `half_full` show a write, a pop or a clear from the edge that accepts it. A start bit appears on `txd` at the first enabled edge after data is present. Every later bit change happens on the 16th enabled edge after the previous one. The bench drives inputs on falling edges. A behavioural model made of a byte queue and a few integers advances on each rising edge, and all three outputs are compared with it on the following falling edge. This makes every result due one edge after its cause. The enable pattern changes between runs: sparse, every cycle, and stopped for long stretches. These patterns cover the R3 hold behaviour, overflow while stopped, and a clear issued in the middle of a frame.

// File: rtl/stq_pkg.sv
package stq_pkg;

    localparam int TX_DATA_W = 8;
    localparam int TX_DEPTH  = 16;
    localparam int TX_OVS    = 16;

    localparam int TX_SUB_W  = $clog2(TX_OVS);
    localparam int TX_LAST   = TX_DATA_W + 1;
    localparam int TX_POS_W  = $clog2(TX_LAST + 1);

    typedef struct packed {
        logic                  busy;
        logic                  line;
        logic [TX_SUB_W-1:0]   sub;
        logic [TX_POS_W-1:0]   pos;
        logic [TX_DATA_W-1:0]  shreg;
    } tx_state_t;

    function automatic tx_state_t idle_state();
        tx_state_t s;
        s.busy  = 1'b0;
        s.line  = 1'b1;
        s.sub   = '0;
        s.pos   = '0;
        s.shreg = '0;
        return s;
    endfunction

    function automatic tx_state_t load_state(input logic [TX_DATA_W-1:0] b);
        tx_state_t s;
        s.busy  = 1'b1;
        s.line  = 1'b0;
        s.sub   = '0;
        s.pos   = '0;
        s.shreg = b;
        return s;
    endfunction

endpackage

// File: rtl/stq_fifo.sv
module stq_fifo #(
    parameter int DATA_W = stq_pkg::TX_DATA_W,
    parameter int DEPTH  = stq_pkg::TX_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic              half
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              push_ok, pop_ok;

    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign half  = (count >= CNT_W'(DEPTH / 2));
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok && !clr && !rst) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    p_full_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> full);
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty);
    p_full_implies_half_r7: assert property (@(posedge clk) disable iff (rst)
        full |-> half);
endmodule

// File: rtl/stq_shifter.sv
module stq_shifter #(
    parameter int DATA_W = stq_pkg::TX_DATA_W,
    parameter int OVS    = stq_pkg::TX_OVS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              have_data,
    input  logic [DATA_W-1:0] head,
    output logic              take,
    output logic              line
);
    import stq_pkg::*;

    tx_state_t st, nxt;

    always_comb begin
        nxt  = st;
        take = 1'b0;
        if (tick) begin
            if (!st.busy) begin
                if (have_data) begin
                    nxt  = load_state(head);
                    take = 1'b1;
                end
            end else if (st.sub == TX_SUB_W'(OVS - 1)) begin
                nxt.sub = '0;
                if (st.pos == TX_POS_W'(TX_LAST)) begin
                    if (have_data) begin
                        nxt  = load_state(head);
                        take = 1'b1;
                    end else begin
                        nxt = idle_state();
                    end
                end else begin
                    nxt.pos = st.pos + 1'b1;
                    if (st.pos == '0) begin
                        nxt.line = st.shreg[0];
                    end else if (st.pos < TX_POS_W'(DATA_W)) begin
                        nxt.shreg = st.shreg >> 1;
                        nxt.line  = st.shreg[1];
                    end else begin
                        nxt.line = 1'b1;
                    end
                end
            end else begin
                nxt.sub = st.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= idle_state();
        else     st <= nxt;
    end

    assign line = st.line;

    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !st.busy |-> line);
    p_hold_without_tick_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(line));
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        take |=> !line);
    p_take_needs_data_r5: assert property (@(posedge clk) disable iff (rst)
        take |-> (have_data && tick));
endmodule

// File: rtl/serial_tx_queue.sv
module serial_tx_queue #(
    parameter int DATA_W = stq_pkg::TX_DATA_W,
    parameter int DEPTH  = stq_pkg::TX_DEPTH,
    parameter int OVS    = stq_pkg::TX_OVS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_clr,
    input  logic              baud16_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              full,
    output logic              half_full
);
    logic [DATA_W-1:0] head;
    logic              empty, take;

    stq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .clr(buf_clr),
        .push(wr_en), .push_data(wr_data), .pop(take),
        .head(head), .empty(empty), .full(full), .half(half_full)
    );

    stq_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
        .clk(clk), .rst(rst), .tick(baud16_en),
        .have_data(!empty), .head(head), .take(take), .line(txd)
    );
endmodule

// File: tb/serial_tx_queue_tb.sv
module serial_tx_queue_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic buf_clr = 1'b0;
    logic baud16_en = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic txd, full, half_full;

    int checks = 0;
    int failures = 0;
    int tick_period = 0;
    int tick_cnt = 0;
    bit done = 1'b0;

    byte unsigned q[$];
    int  m_busy = 0, m_sub = 0, m_pos = 0;
    byte unsigned m_cur = 0;
    bit  m_line = 1'b1;

    serial_tx_queue u_dut (
        .clk(clk), .rst(rst), .buf_clr(buf_clr), .baud16_en(baud16_en),
        .wr_en(wr_en), .wr_data(wr_data),
        .txd(txd), .full(full), .half_full(half_full)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // enable generator: period 0 means stopped
    always @(negedge clk) begin
        if (tick_period == 0) begin
            baud16_en <= 1'b0;
            tick_cnt  <= 0;
        end else if (tick_cnt >= tick_period - 1) begin
            baud16_en <= 1'b1;
            tick_cnt  <= 0;
        end else begin
            baud16_en <= 1'b0;
            tick_cnt  <= tick_cnt + 1;
        end
    end

    // behavioural reference
    always @(posedge clk) begin
        int  old_n;
        bit  popped;
        old_n  = q.size();
        popped = 1'b0;
        if (rst) begin
            q.delete();
            m_busy = 0; m_line = 1'b1; m_sub = 0; m_pos = 0;
        end else begin
            if (baud16_en) begin
                if (m_busy == 0 || (m_sub == 15 && m_pos == 9)) begin
                    if (old_n > 0) begin
                        m_cur = q[0]; popped = 1'b1;
                        m_busy = 1; m_sub = 0; m_pos = 0; m_line = 1'b0;
                    end else begin
                        m_busy = 0; m_line = 1'b1; m_sub = 0; m_pos = 0;
                    end
                end else if (m_sub == 15) begin
                    m_sub = 0;
                    m_pos++;
                    m_line = (m_pos <= 8) ? m_cur[m_pos-1] : 1'b1;
                end else begin
                    m_sub++;
                end
            end
            if (buf_clr) q.delete();
            else begin
                if (popped) void'(q.pop_front());
                if (wr_en && old_n < 16) q.push_back(wr_data);
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 R3 R5 txd", txd, m_line);
            check("R6 full", full, q.size() == 16);
            check("R7 half_full", half_full, q.size() >= 8);
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put(input byte unsigned b);
        wr_en <= 1'b1; wr_data <= b;
        @(negedge clk);
        wr_en <= 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; failures++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cycles(3);
        rst <= 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 txd idle", txd, 1'b1);
        check("R1 full", full, 1'b0);
        check("R1 half_full", half_full, 1'b0);

        // R2 R4 R5: single frame with sparse enables
        tick_period = 4;
        put(8'hA5);
        cycles(700);

        // R5: back-to-back frames
        put(8'h3C); put(8'h01); put(8'hFE);
        cycles(2000);

        // R3 R6 R7 R8: enables stopped, fill past capacity
        tick_period = 0;
        cycles(4);
        for (int i = 0; i < 20; i++) put(byte'(8'h10 + i));
        cycles(50);
        // R8: one more write while full
        put(8'hEE);
        // R8: drain with an enable on every cycle; order shows data intact
        tick_period = 1;
        cycles(2800);

        // R9: clear while a frame is in flight
        tick_period = 2;
        for (int i = 0; i < 10; i++) put(byte'(8'h80 + i));
        cycles(60);
        buf_clr <= 1'b1; wr_en <= 1'b1; wr_data <= 8'h55;
        @(negedge clk);
        buf_clr <= 1'b0; wr_en <= 1'b0;
        check("R9 cleared half_full", half_full, 1'b0);
        check("R9 cleared full", full, 1'b0);
        cycles(400);

        // R4 R5: writes arriving while the serializer pops
        tick_period = 3;
        for (int i = 0; i < 12; i++) begin
            put(byte'(8'hC0 ^ i));
            cycles(37);
        end
        cycles(6500);
        check("R5 idle after drain", txd, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule